// File: doc/BRIEF.md
# Reprogrammable Gate Netlist Evaluator

The block holds a small feed-forward logic netlist as a list of node genes in registers and evaluates it over a primary input vector. Every signal lives in one index space: two constant signals, then the primary input bits, then the nodes. Each node reads two signals with lower indices and applies one of ten gate functions. One node is evaluated per clock, in ascending index order, so a node can use any result computed before it. When the last node is done, each output bit takes the value of the signal its output gene names, and a one-cycle completion pulse is raised.

Software or a test sequencer writes node genes and output genes through a simple write port while the block is idle, pulses `start` with an input vector applied, and reads `out_bits` after `done`. A gene that names an unknown function, reads a signal that is not strictly older than its node, or selects a signal outside the index space raises a sticky configuration error that blocks further evaluation until reset. Input, node and output counts are parameters.

Top module: `cgp_eval_top`

## Requirements
- R1: Signal index 0 always reads as 0 and signal index 1 always reads as 1, for node sources and for output selection alike.
- R2: Primary input bit `in_bits[k]` has signal index k+2; with two operands packed as `in_bits = {b, a}`, the bits of `a` come first from its LSB up, then the bits of `b`.
- R3: A node's function code (bits [3:0] of its gene) selects: 0 pass source A, 1 invert A, 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 XNOR, 8 constant 1, 9 constant 0.
- R4: Node j (gene address j, 0 <= j < N_NODES) has signal index N_IN+2+j; nodes are evaluated in ascending order, so a node sees the final value of every node with a lower index.
- R5: Output gene k (gene address N_NODES+k, index in the source-A field) drives `out_bits[k]` with the named signal, which may be a constant, an input or a node.
- R6: After `start` is sampled while idle and error-free, `busy` is high for exactly N_NODES cycles; `done` is high for exactly one cycle, the first cycle with `busy` low.
- R7: `out_bits` changes only in the cycle `done` is raised and holds its value otherwise, including across writes to output genes.
- R8: While `busy` is high, gene writes and `start` pulses are ignored.
- R9: Writing a node gene with a function code above 9, or with a source index not below the node's own index, or an output gene naming an index at or above N_IN+2+N_NODES sets `cfg_error`; it stays set until reset, and `start` is ignored while it is set.
- R10: After reset `out_bits`, `busy`, `done` and `cfg_error` are 0, and every gene is zero (nodes pass index 0, outputs select index 0).
- R11: A gene word is `{src_a, src_b, func}` with `func` in bits [3:0], `src_b` in the next IDX_W bits and `src_a` in the top IDX_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Gene write enable |
| cfg_addr | input | ADDR_W | Gene address: nodes first, then outputs |
| cfg_data | input | GENE_W | Gene word {src_a, src_b, func} |
| start | input | 1 | Start pulse; samples `in_bits` |
| in_bits | input | N_IN | Primary input vector |
| out_bits | output | N_OUT | Selected output signals of the last evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_error | output | 1 | Sticky configuration error |

## Verification
A genome built as a two-bit adder plus a chain through every function code is run over eight input vectors that set and clear the carry paths and each gate's operands in turn, so a wrong function code, a wrong input index or a node read before it is written shows as a wrong sum or gate bit. Directed runs then retarget output genes at constants and at the top input bit, write genes and pulse `start` during an evaluation, and load illegal genes right at the index boundary, telling ignored writes, held outputs and the error rules apart from the evaluation itself.

// File: rtl/cgp_eval_pkg.sv
package cgp_eval_pkg;

   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      GF_PASS  = 4'd0,
      GF_INV   = 4'd1,
      GF_AND   = 4'd2,
      GF_OR    = 4'd3,
      GF_XOR   = 4'd4,
      GF_NAND  = 4'd5,
      GF_NOR   = 4'd6,
      GF_XNOR  = 4'd7,
      GF_ONE   = 4'd8,
      GF_ZERO  = 4'd9
   } gate_fn_e;

   localparam logic [FUNC_W-1:0] GF_MAX_LEGAL = 4'd9;

   function automatic logic gate_apply(input logic [FUNC_W-1:0] fn,
                                       input logic a, input logic b);
      logic y;
      case (gate_fn_e'(fn))
         GF_PASS: y = a;
         GF_INV:  y = ~a;
         GF_AND:  y = a & b;
         GF_OR:   y = a | b;
         GF_XOR:  y = a ^ b;
         GF_NAND: y = ~(a & b);
         GF_NOR:  y = ~(a | b);
         GF_XNOR: y = ~(a ^ b);
         GF_ONE:  y = 1'b1;
         default: y = 1'b0;
      endcase
      return y;
   endfunction

endpackage

// File: rtl/cgp_gate_unit.sv
module cgp_gate_unit
   import cgp_eval_pkg::*;
(
   input  logic [FUNC_W-1:0] fn,
   input  logic              op_a,
   input  logic              op_b,
   output logic              y
);
   always_comb y = gate_apply(fn, op_a, op_b);
endmodule

// File: rtl/cgp_genome_store.sv
module cgp_genome_store
   import cgp_eval_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int N_NODES = 16,
   parameter int N_OUT   = 5,
   parameter int IDX_W   = 5,
   parameter int ADDR_W  = 5,
   parameter int NODE_W  = 4,
   parameter int OUT_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [2*IDX_W+FUNC_W-1:0] wr_data,
   input  logic [NODE_W-1:0]       rd_node,
   output logic [IDX_W-1:0]        rd_src_a,
   output logic [IDX_W-1:0]        rd_src_b,
   output logic [FUNC_W-1:0]       rd_fn,
   output logic [N_OUT*IDX_W-1:0]  out_sel,
   output logic                    cfg_error
);
   localparam int NSIG = N_IN + 2 + N_NODES;

   logic [IDX_W-1:0]  node_a [N_NODES];
   logic [IDX_W-1:0]  node_b [N_NODES];
   logic [FUNC_W-1:0] node_f [N_NODES];
   logic [IDX_W-1:0]  osel   [N_OUT];

   logic [IDX_W-1:0]  w_a, w_b;
   logic [FUNC_W-1:0] w_f;
   logic              is_node, is_out;
   logic [IDX_W+ADDR_W:0] own_idx;
   logic              bad_node, bad_out;

   always_comb begin
      w_f     = wr_data[FUNC_W-1:0];
      w_b     = wr_data[FUNC_W +: IDX_W];
      w_a     = wr_data[FUNC_W+IDX_W +: IDX_W];
      is_node = ({1'b0, wr_addr} < (ADDR_W+1)'(N_NODES));
      is_out  = !is_node && ({1'b0, wr_addr} < (ADDR_W+1)'(N_NODES + N_OUT));
      own_idx = (IDX_W+ADDR_W+1)'(N_IN + 2) + (IDX_W+ADDR_W+1)'(wr_addr);
      bad_node = (w_f > GF_MAX_LEGAL)
              || ((IDX_W+ADDR_W+1)'(w_a) >= own_idx)
              || ((IDX_W+ADDR_W+1)'(w_b) >= own_idx);
      bad_out  = ((IDX_W+1)'(w_a) >= (IDX_W+1)'(NSIG));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_NODES; i++) begin
            node_a[i] <= '0;
            node_b[i] <= '0;
            node_f[i] <= '0;
         end
         for (int k = 0; k < N_OUT; k++) osel[k] <= '0;
         cfg_error <= 1'b0;
      end else if (wr_en) begin
         if (is_node) begin
            node_a[wr_addr[NODE_W-1:0]] <= w_a;
            node_b[wr_addr[NODE_W-1:0]] <= w_b;
            node_f[wr_addr[NODE_W-1:0]] <= w_f;
            if (bad_node) cfg_error <= 1'b1;
         end else if (is_out) begin
            osel[OUT_W'(wr_addr - ADDR_W'(N_NODES))] <= w_a;
            if (bad_out) cfg_error <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_src_a = node_a[rd_node];
      rd_src_b = node_b[rd_node];
      rd_fn    = node_f[rd_node];
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_osel
      assign out_sel[k*IDX_W +: IDX_W] = osel[k];
   end
endmodule

// File: rtl/cgp_eval_core.sv
module cgp_eval_core
   import cgp_eval_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int N_NODES = 16,
   parameter int N_OUT   = 5,
   parameter int IDX_W   = 5,
   parameter int NODE_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   blocked,
   input  logic [N_IN-1:0]        in_bits,
   input  logic [IDX_W-1:0]       src_a,
   input  logic [IDX_W-1:0]       src_b,
   input  logic [FUNC_W-1:0]      fn,
   input  logic [N_OUT*IDX_W-1:0] out_sel,
   output logic [NODE_W-1:0]      node_ptr,
   output logic [N_OUT-1:0]       out_bits,
   output logic                   busy,
   output logic                   done
);
   localparam int NSIG = N_IN + 2 + N_NODES;
   localparam logic [NODE_W-1:0] LAST = NODE_W'(N_NODES - 1);

   logic [N_IN-1:0]    in_q;
   logic [N_NODES-1:0] node_q, node_nxt;
   logic [NSIG-1:0]    sig, sig_nxt;
   logic [N_OUT-1:0]   out_nxt;
   logic               op_a, op_b, res;

   always_comb begin
      sig  = {node_q, in_q, 2'b10};
      op_a = sig[src_a];
      op_b = sig[src_b];
   end

   cgp_gate_unit u_gate (
      .fn   (fn),
      .op_a (op_a),
      .op_b (op_b),
      .y    (res)
   );

   always_comb begin
      node_nxt           = node_q;
      node_nxt[node_ptr] = res;
      sig_nxt            = {node_nxt, in_q, 2'b10};
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_omux
      logic [IDX_W-1:0] sel;
      assign sel        = out_sel[k*IDX_W +: IDX_W];
      assign out_nxt[k] = ((IDX_W+1)'(sel) < (IDX_W+1)'(NSIG)) ? sig_nxt[sel] : 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         node_ptr <= '0;
         in_q     <= '0;
         node_q   <= '0;
         out_bits <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start && !blocked) begin
               busy     <= 1'b1;
               node_ptr <= '0;
               in_q     <= in_bits;
            end
         end else begin
            node_q <= node_nxt;
            if (node_ptr == LAST) begin
               busy     <= 1'b0;
               done     <= 1'b1;
               out_bits <= out_nxt;
            end else begin
               node_ptr <= node_ptr + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cgp_eval_top.sv
module cgp_eval_top
   import cgp_eval_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int N_NODES = 16,
   parameter int N_OUT   = 5,
   localparam int NSIG   = N_IN + 2 + N_NODES,
   localparam int IDX_W  = $clog2(NSIG),
   localparam int ADDR_W = $clog2(N_NODES + N_OUT + 1),
   localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1,
   localparam int OUT_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int GENE_W = 2*IDX_W + FUNC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [GENE_W-1:0] cfg_data,
   input  logic              start,
   input  logic [N_IN-1:0]   in_bits,
   output logic [N_OUT-1:0]  out_bits,
   output logic              busy,
   output logic              done,
   output logic              cfg_error
);
   if (N_IN < 1)    begin : g_bad_in   $error("N_IN must be at least 1");    end
   if (N_NODES < 1) begin : g_bad_node $error("N_NODES must be at least 1"); end
   if (N_OUT < 1)   begin : g_bad_out  $error("N_OUT must be at least 1");   end

   logic [NODE_W-1:0]      node_ptr;
   logic [IDX_W-1:0]       src_a, src_b;
   logic [FUNC_W-1:0]      fn;
   logic [N_OUT*IDX_W-1:0] out_sel;
   logic                   wr_ok;

   assign wr_ok = cfg_we && !busy;

   cgp_genome_store #(
      .N_IN(N_IN), .N_NODES(N_NODES), .N_OUT(N_OUT),
      .IDX_W(IDX_W), .ADDR_W(ADDR_W), .NODE_W(NODE_W), .OUT_W(OUT_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ok),
      .wr_addr   (cfg_addr),
      .wr_data   (cfg_data),
      .rd_node   (node_ptr),
      .rd_src_a  (src_a),
      .rd_src_b  (src_b),
      .rd_fn     (fn),
      .out_sel   (out_sel),
      .cfg_error (cfg_error)
   );

   cgp_eval_core #(
      .N_IN(N_IN), .N_NODES(N_NODES), .N_OUT(N_OUT),
      .IDX_W(IDX_W), .NODE_W(NODE_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .blocked  (cfg_error),
      .in_bits  (in_bits),
      .src_a    (src_a),
      .src_b    (src_b),
      .fn       (fn),
      .out_sel  (out_sel),
      .node_ptr (node_ptr),
      .out_bits (out_bits),
      .busy     (busy),
      .done     (done)
   );
endmodule

// File: rtl/cgp_eval_checker.sv
module cgp_eval_checker #(
   parameter int N_NODES = 16,
   parameter int N_OUT   = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             cfg_error,
   input logic [N_OUT-1:0] out_bits
);
   int unsigned busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_run <= 0;
      else        busy_run <= busy ? busy_run + 1 : 0;
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == N_NODES));

   a_r7_out_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(out_bits));

   a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   a_r9_error_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_error && !busy) |=> !busy);

   a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind cgp_eval_top cgp_eval_checker #(.N_NODES(N_NODES), .N_OUT(N_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .cfg_error (cfg_error),
   .out_bits  (out_bits)
);

// File: tb/cgp_eval_top_tb.sv
module cgp_eval_top_tb;
   localparam int N_IN = 8, N_NODES = 16, N_OUT = 5;
   localparam int ADDR_W = 5, GENE_W = 14, IDX_W = 5;

   logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, start = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [GENE_W-1:0] cfg_data = '0;
   logic [N_IN-1:0]   in_bits = '0;
   logic [N_OUT-1:0]  out_bits;
   logic busy, done, cfg_error;

   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cgp_eval_top #(.N_IN(N_IN), .N_NODES(N_NODES), .N_OUT(N_OUT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .start(start), .in_bits(in_bits),
      .out_bits(out_bits), .busy(busy), .done(done), .cfg_error(cfg_error)
   );

   // node genes {src_a, src_b, func}: two-bit adder and a chain over all codes
   localparam logic [13:0] GENOME [16] = '{
      {5'd2,  5'd6,  4'd4}, {5'd2,  5'd6,  4'd2}, {5'd3,  5'd7,  4'd4},
      {5'd12, 5'd11, 4'd4}, {5'd3,  5'd7,  4'd2}, {5'd12, 5'd11, 4'd2},
      {5'd14, 5'd15, 4'd3}, {5'd4,  5'd8,  4'd5}, {5'd5,  5'd9,  4'd6},
      {5'd17, 5'd18, 4'd7}, {5'd19, 5'd0,  4'd1}, {5'd0,  5'd0,  4'd8},
      {5'd0,  5'd0,  4'd9}, {5'd20, 5'd0,  4'd0}, {5'd22, 5'd21, 4'd3},
      {5'd24, 5'd23, 4'd2}};
   localparam logic [4:0] OUTSEL [5] = '{5'd10, 5'd13, 5'd16, 5'd25, 5'd1};
   // {in_bits, expected out_bits}
   localparam logic [12:0] VEC [8] = '{
      {8'h00, 5'b10000}, {8'h33, 5'b10110}, {8'hFF, 5'b10110},
      {8'h14, 5'b10001}, {8'h28, 5'b11010}, {8'h56, 5'b11011},
      {8'hC1, 5'b11001}, {8'h7E, 5'b10101}};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int addr, input int sa, input int sb, input int fn);
      cfg_we   = 1'b1;
      cfg_addr = ADDR_W'(addr);
      cfg_data = {IDX_W'(sa), IDX_W'(sb), 4'(fn)};
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // runs one evaluation; optional disturbance at third busy cycle
   task automatic run(input logic [7:0] vin, input bit disturb, output int cyc);
      start   = 1'b1;
      in_bits = vin;
      @(negedge clk);
      start   = 1'b0;
      in_bits = ~vin;
      cyc = 0;
      while (!done && cyc < 300) begin
         if (disturb && cyc == 2) begin
            cfg_we = 1'b1; cfg_addr = 5'd16; cfg_data = {5'd1, 5'd0, 4'd0};
            start = 1'b1;
         end
         @(negedge clk);
         cfg_we = 1'b0; start = 1'b0;
         cyc++;
      end
      if (cyc >= 300) chk(0, "R6 watchdog", cyc, N_NODES);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL R6 global watchdog: actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int cyc;
      do_reset();
      // R10 reset state
      chk(out_bits == 0, "R10 out", out_bits, 0);
      chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
      chk(!cfg_error, "R10 error", cfg_error, 0);
      // R1/R10 zero genome: every output selects index 0
      run(8'hFF, 0, cyc);
      chk(out_bits == 0, "R1 index0 zero", out_bits, 0);

      for (int j = 0; j < 16; j++) wr(j, GENOME[j][13:9], GENOME[j][8:4], GENOME[j][3:0]);
      for (int k = 0; k < 5; k++) wr(16 + k, OUTSEL[k], 0, 0);
      chk(!cfg_error, "R11 legal genome", cfg_error, 0);

      // R2 R3 R4 R5 table walk
      for (int v = 0; v < 8; v++) begin
         run(VEC[v][12:5], 0, cyc);
         chk(out_bits == VEC[v][4:0], "R3 R4 table", out_bits, VEC[v][4:0]);
         chk(cyc == N_NODES, "R6 busy cycles", cyc, N_NODES);
         chk(done && !busy, "R6 done with busy low", {done, busy}, 2);
         @(negedge clk);
         chk(!done, "R6 done one cycle", done, 0);
      end

      // R7 output gene write does not move outputs
      wr(16, 0, 0, 0);
      repeat (2) @(negedge clk);
      chk(out_bits == 5'b10101, "R7 held", out_bits, 5'b10101);
      run(8'h7E, 0, cyc);
      chk(out_bits == 5'b10100, "R5 out0 to const0", out_bits, 5'b10100);

      // R8 write and start during busy ignored
      run(8'h00, 1, cyc);
      chk(cyc == N_NODES, "R8 start ignored while busy", cyc, N_NODES);
      chk(out_bits == 5'b10000, "R8 run result", out_bits, 5'b10000);
      repeat (3) @(negedge clk);
      chk(!busy, "R8 no restart", busy, 0);
      run(8'h00, 0, cyc);
      chk(out_bits == 5'b10000, "R8 write ignored", out_bits, 5'b10000);

      // R2 R5 output selects top input bit (index 9 = in_bits[7])
      wr(17, 9, 0, 0);
      run(8'h80, 0, cyc);
      chk(out_bits == 5'b11010, "R2 input index 9", out_bits, 5'b11010);

      // R9 illegal function code
      wr(5, 0, 0, 10);
      chk(cfg_error, "R9 func 10", cfg_error, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(!busy, "R9 start blocked", busy, 0);
      repeat (3) @(negedge clk);
      chk(cfg_error && !busy, "R9 sticky", {cfg_error, busy}, 2);

      // R9 source boundary: node 0 has index 10
      do_reset();
      chk(!cfg_error, "R10 error cleared", cfg_error, 0);
      wr(0, 9, 9, 4);
      chk(!cfg_error, "R9 src 9 legal", cfg_error, 0);
      wr(0, 0, 10, 4);
      chk(cfg_error, "R9 src_b 10 illegal", cfg_error, 1);

      // R9 output index range
      do_reset();
      wr(18, 26, 0, 0);
      chk(cfg_error, "R9 out index 26", cfg_error, 1);

      // R1 output selects constant one
      do_reset();
      wr(16, 1, 0, 0);
      run(8'h00, 0, cyc);
      chk(out_bits == 5'b00001, "R1 index1 one", out_bits, 5'b00001);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule